// File: doc/BRIEF.md
# Reservation Station Bank with Rename Table and Result Bus Snooping

This block holds the waiting instructions for one class of execution unit in an out-of-order core. An issue port hands it an operation, a destination register and two source register numbers. The block places the instruction in a free station. For each source it either copies the current register value or records the tag of the station that will produce that value. It also updates a per-register rename table, so that later readers of the destination register wait on the new station.

Waiting stations watch a shared result bus that carries a data word and a producer tag. When a broadcast tag matches a pending source, the station takes the data. A station whose two sources are both resolved is handed to the execution unit, one station per cycle. The station stays occupied until its own result appears on the bus. That broadcast also writes the register file, but only when the rename entry still names the broadcasting station.

Top module: `rsv_bank`

## Requirements
- R1: After a synchronous active-high reset, all stations are free and no register has a pending producer. `iss_ready` is 1 and `dsp_valid` is 0. Register r holds the value 100 + r.
- R2: An issue is accepted when `iss_valid` and `iss_ready` are both high. It takes the lowest-numbered free station, and station index i carries tag i+1 (tag 0 means "no producer"). `iss_ready` is low while every station is occupied. An issue offered while `iss_ready` is low occupies no station and leaves the rename table unchanged.
- R3: A source register with no pending producer takes the register file value at issue. A source register with a pending producer records that producer's tag, and the station waits.
- R4: If an issue names a source whose pending producer broadcasts on the result bus in the same cycle, the station takes the bus data directly and does not wait.
- R5: Every occupied station with a source waiting on the broadcast tag takes the bus data at that clock edge. All matching stations capture the data, not only one.
- R6: A station is dispatched only when both its sources hold values, and it is dispatched exactly once. When several stations are ready, the lowest-numbered one goes first. The dispatch outputs carry the station tag, the operation and both operand values.
- R7: A broadcast carrying a station's tag frees that station. The station can accept an issue from the next cycle on.
- R8: An accepted issue sets the rename entry of its destination to the new tag. A broadcast clears a rename entry and writes the register file only if that entry still holds the broadcasting tag, so a newer rename of the same register is kept.
- R9: A station whose sources are both resolved at issue shows on the dispatch outputs in the cycle right after the issue edge. A station completed by a broadcast shows in the cycle right after that broadcast edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 4 | Operation code passed through to dispatch |
| iss_dst | input | 4 | Destination register number |
| iss_src_a | input | 4 | First source register number |
| iss_src_b | input | 4 | Second source register number |
| iss_ready | output | 1 | At least one station is free |
| res_valid | input | 1 | Result bus carries a broadcast |
| res_tag | input | 4 | Tag of the producing station |
| res_data | input | 64 | Broadcast result value |
| dsp_valid | output | 1 | A station is dispatched this cycle |
| dsp_tag | output | 4 | Tag of the dispatched station |
| dsp_op | output | 4 | Operation of the dispatched station |
| dsp_opa | output | 64 | First operand value |
| dsp_opb | output | 64 | Second operand value |

## Verification
A table of independent instructions, with each result broadcast before the next issue, confirms that operands come from the register file and that broadcasts write back. Chains in which a reader is issued before its producer completes separate operands taken by tag capture from operands read at issue. Each of the following tests isolates one mechanism:
- An issue in the same cycle as the matching broadcast checks the bypass.
- Two renames of one register show whether a stale broadcast is wrongly allowed to clear the mapping.
- Two stations waiting on one tag expose both the multi-capture and the dispatch order.
- Filling every station, followed by a refused issue, shows that the refused issue has no effect and that a freed tag is reused.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    localparam int NUM_STN   = 4;
    localparam int NUM_REG   = 16;
    localparam int DATA_W    = 64;
    localparam int TAG_W     = 4;
    localparam int OP_W      = 4;
    localparam int REG_W     = $clog2(NUM_REG);
    localparam int IDX_W     = (NUM_STN > 1) ? $clog2(NUM_STN) : 1;
    localparam int INIT_BASE = 100;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [OP_W-1:0]   op_t;
    typedef logic [REG_W-1:0]  reg_t;

    // One source operand: q == 0 means v is valid
    typedef struct packed {
        tag_t  q;
        word_t v;
    } opnd_t;

    typedef struct packed {
        logic  busy;
        logic  done;
        op_t   op;
        opnd_t j;
        opnd_t k;
    } stn_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        word_t data;
    } bus_t;

    function automatic word_t reg_init(int r);
        return word_t'(INIT_BASE + r);
    endfunction

    function automatic tag_t stn_tag(int idx);
        return tag_t'(idx + 1);
    endfunction

    // Operand resolution at issue time, including same-cycle bus bypass
    function automatic opnd_t resolve(tag_t pend, word_t regval, bus_t bus);
        opnd_t o;
        if (pend == '0) begin
            o.q = '0;
            o.v = regval;
        end else if (bus.valid && bus.tag == pend) begin
            o.q = '0;
            o.v = bus.data;
        end else begin
            o.q = pend;
            o.v = '0;
        end
        return o;
    endfunction

    // Operand update while waiting in a station
    function automatic opnd_t snoop(opnd_t cur, bus_t bus);
        opnd_t o;
        o = cur;
        if (cur.q != '0 && bus.valid && bus.tag == cur.q) begin
            o.q = '0;
            o.v = bus.data;
        end
        return o;
    endfunction
endpackage

// File: rtl/rsv_pick.sv
module rsv_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/rsv_rename.sv
module rsv_rename
    import rsv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  reg_t  src_a,
    input  reg_t  src_b,
    output tag_t  tag_a,
    output tag_t  tag_b,
    output word_t val_a,
    output word_t val_b,
    input  logic  ren_en,
    input  reg_t  ren_reg,
    input  tag_t  ren_tag,
    input  bus_t  bus
);
    tag_t  pend_q [NUM_REG];
    word_t file_q [NUM_REG];

    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_REG; r++) begin
            if (rst) begin
                pend_q[r] <= '0;
                file_q[r] <= reg_init(r);
            end else begin
                // Write back only when this register still waits on the broadcaster
                if (bus.valid && bus.tag != '0 && pend_q[r] == bus.tag) begin
                    file_q[r] <= bus.data;
                    pend_q[r] <= '0;
                end
                // A new rename overrides a same-cycle clear
                if (ren_en && ren_reg == reg_t'(r)) begin
                    pend_q[r] <= ren_tag;
                end
            end
        end
    end

    assign tag_a = pend_q[src_a];
    assign tag_b = pend_q[src_b];
    assign val_a = file_q[src_a];
    assign val_b = file_q[src_b];
endmodule

// File: rtl/rsv_station.sv
module rsv_station
    import rsv_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc,
    input  op_t   alloc_op,
    input  opnd_t alloc_j,
    input  opnd_t alloc_k,
    input  bus_t  bus,
    input  logic  grant,
    output stn_t  ent,
    output logic  ready
);
    localparam tag_t MY_TAG = stn_tag(IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (alloc) begin
            ent.busy <= 1'b1;
            ent.done <= 1'b0;
            ent.op   <= alloc_op;
            ent.j    <= alloc_j;
            ent.k    <= alloc_k;
        end else if (ent.busy) begin
            if (bus.valid && bus.tag == MY_TAG) begin
                ent.busy <= 1'b0;
                ent.done <= 1'b0;
            end else begin
                if (grant) ent.done <= 1'b1;
                ent.j <= snoop(ent.j, bus);
                ent.k <= snoop(ent.k, bus);
            end
        end
    end

    assign ready = ent.busy && !ent.done && (ent.j.q == '0) && (ent.k.q == '0);
endmodule

// File: rtl/rsv_bank.sv
module rsv_bank (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        iss_valid,
    input  logic [rsv_pkg::OP_W-1:0]    iss_op,
    input  logic [rsv_pkg::REG_W-1:0]   iss_dst,
    input  logic [rsv_pkg::REG_W-1:0]   iss_src_a,
    input  logic [rsv_pkg::REG_W-1:0]   iss_src_b,
    output logic                        iss_ready,
    input  logic                        res_valid,
    input  logic [rsv_pkg::TAG_W-1:0]   res_tag,
    input  logic [rsv_pkg::DATA_W-1:0]  res_data,
    output logic                        dsp_valid,
    output logic [rsv_pkg::TAG_W-1:0]   dsp_tag,
    output logic [rsv_pkg::OP_W-1:0]    dsp_op,
    output logic [rsv_pkg::DATA_W-1:0]  dsp_opa,
    output logic [rsv_pkg::DATA_W-1:0]  dsp_opb
);
    import rsv_pkg::*;

    bus_t                bus;
    stn_t                ent [NUM_STN];
    logic [NUM_STN-1:0]  stn_busy;
    logic [NUM_STN-1:0]  stn_ready;
    logic [NUM_STN-1:0]  free_vec;
    logic [IDX_W-1:0]    free_idx;
    logic [IDX_W-1:0]    dsp_idx;
    logic                issue_go;
    tag_t                new_tag;
    tag_t                tag_a, tag_b;
    word_t               val_a, val_b;
    opnd_t               opnd_a, opnd_b;

    assign bus.valid = res_valid;
    assign bus.tag   = res_tag;
    assign bus.data  = res_data;

    assign free_vec = ~stn_busy;

    rsv_pick #(.N(NUM_STN), .IW(IDX_W)) u_free_pick (
        .req (free_vec),
        .any (iss_ready),
        .idx (free_idx)
    );

    assign issue_go = iss_valid && iss_ready;
    assign new_tag  = tag_t'(free_idx) + tag_t'(1);

    rsv_rename u_rename (
        .clk     (clk),
        .rst     (rst),
        .src_a   (iss_src_a),
        .src_b   (iss_src_b),
        .tag_a   (tag_a),
        .tag_b   (tag_b),
        .val_a   (val_a),
        .val_b   (val_b),
        .ren_en  (issue_go),
        .ren_reg (iss_dst),
        .ren_tag (new_tag),
        .bus     (bus)
    );

    assign opnd_a = resolve(tag_a, val_a, bus);
    assign opnd_b = resolve(tag_b, val_b, bus);

    for (genvar g = 0; g < NUM_STN; g++) begin : g_stn
        logic alloc_g;
        logic grant_g;
        assign alloc_g = issue_go && (free_idx == IDX_W'(g));
        assign grant_g = dsp_valid && (dsp_idx == IDX_W'(g));

        rsv_station #(.IDX(g)) u_stn (
            .clk      (clk),
            .rst      (rst),
            .alloc    (alloc_g),
            .alloc_op (iss_op),
            .alloc_j  (opnd_a),
            .alloc_k  (opnd_b),
            .bus      (bus),
            .grant    (grant_g),
            .ent      (ent[g]),
            .ready    (stn_ready[g])
        );
        assign stn_busy[g] = ent[g].busy;
    end

    rsv_pick #(.N(NUM_STN), .IW(IDX_W)) u_dsp_pick (
        .req (stn_ready),
        .any (dsp_valid),
        .idx (dsp_idx)
    );

    always_comb begin
        dsp_tag = '0;
        dsp_op  = '0;
        dsp_opa = '0;
        dsp_opb = '0;
        if (dsp_valid) begin
            dsp_tag = tag_t'(dsp_idx) + tag_t'(1);
            dsp_op  = ent[dsp_idx].op;
            dsp_opa = ent[dsp_idx].j.v;
            dsp_opb = ent[dsp_idx].k.v;
        end
    end
endmodule

// File: rtl/rsv_bank_checker.sv
module rsv_bank_checker
    import rsv_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               iss_valid,
    input logic               iss_ready,
    input logic               res_valid,
    input tag_t               res_tag,
    input logic               dsp_valid,
    input tag_t               dsp_tag,
    input logic [NUM_STN-1:0] busy
);
    logic             res_in_range;
    logic [IDX_W-1:0] res_idx;

    assign res_in_range = (res_tag != '0) && (int'(res_tag) <= NUM_STN);
    assign res_idx      = IDX_W'(res_tag - tag_t'(1));

    // R1: the first cycle after reset shows an idle bank
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (busy == '0 && !dsp_valid));

    // R2: an accepted issue with no release adds exactly one occupied station
    assert_issue_fills_R2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready && !res_valid) |=>
            ($countones(busy) == $past($countones(busy)) + 1));

    // R6: dispatched tags name a real station
    assert_dsp_tag_range_R6: assert property (@(posedge clk) disable iff (rst)
        dsp_valid |-> (dsp_tag != '0 && int'(dsp_tag) <= NUM_STN));

    // R6: a station is never dispatched on two consecutive cycles
    assert_single_dispatch_R6: assert property (@(posedge clk) disable iff (rst)
        dsp_valid |=> !(dsp_valid && dsp_tag == $past(dsp_tag)));

    // R7: a broadcast of an occupied station's tag frees it
    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_in_range && busy[res_idx]) |=> !busy[$past(res_idx)]);
endmodule

bind rsv_bank rsv_bank_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .res_valid (res_valid),
    .res_tag   (res_tag),
    .dsp_valid (dsp_valid),
    .dsp_tag   (dsp_tag),
    .busy      (stn_busy)
);

// File: tb/test_rsv_bank.sv
module test_rsv_bank;
    import rsv_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  iss_valid = 1'b0;
    op_t   iss_op = '0;
    reg_t  iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic  iss_ready;
    logic  res_valid = 1'b0;
    tag_t  res_tag = '0;
    word_t res_data = '0;
    logic  dsp_valid;
    tag_t  dsp_tag;
    op_t   dsp_op;
    word_t dsp_opa, dsp_opb;

    int checks = 0;
    int errors = 0;
    word_t m [NUM_REG];

    always #10 clk = ~clk;

    rsv_bank i_rsv_bank (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_ready(iss_ready),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .dsp_valid(dsp_valid), .dsp_tag(dsp_tag), .dsp_op(dsp_op),
        .dsp_opa(dsp_opa), .dsp_opb(dsp_opb)
    );

    typedef struct packed {
        op_t   op;
        reg_t  dst;
        reg_t  sa;
        reg_t  sb;
        word_t res;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'd1, 4'd2,  4'd3,  4'd4,  64'h0000_0000_0000_1111},
        '{4'd2, 4'd5,  4'd2,  4'd2,  64'hAAAA_0000_0000_BBBB},
        '{4'd3, 4'd2,  4'd5,  4'd2,  64'h0000_0000_0000_0007},
        '{4'd4, 4'd0,  4'd15, 4'd0,  64'hFFFF_FFFF_FFFF_FFFF},
        '{4'd5, 4'd15, 4'd0,  4'd15, 64'h0000_0000_0000_1234},
        '{4'd6, 4'd7,  4'd7,  4'd7,  64'h0000_0000_0000_0000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_issue(input op_t op, input reg_t d, input reg_t a, input reg_t b);
        iss_valid = 1'b1; iss_op = op; iss_dst = d; iss_src_a = a; iss_src_b = b;
    endtask

    task automatic set_bcast(input tag_t t, input word_t v);
        res_valid = 1'b1; res_tag = t; res_data = v;
    endtask

    task automatic idle_inputs;
        iss_valid = 1'b0; res_valid = 1'b0;
    endtask

    task automatic issue(input op_t op, input reg_t d, input reg_t a, input reg_t b);
        set_issue(op, d, a, b);
        tick;
        idle_inputs;
    endtask

    task automatic bcast(input tag_t t, input word_t v);
        set_bcast(t, v);
        tick;
        idle_inputs;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < NUM_REG; r++) m[r] = word_t'(100 + r);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 iss_ready after reset", iss_ready, 1);
        chk("R1 dsp_valid after reset", dsp_valid, 0);

        // Table walk: independent instructions, each completed before the next (R3, R8, R9)
        for (int i = 0; i < 6; i++) begin
            issue(VECS[i].op, VECS[i].dst, VECS[i].sa, VECS[i].sb);
            chk("R9 dispatch after issue", dsp_valid, 1);
            chk("R2 lowest free tag", dsp_tag, 1);
            chk("R6 dispatched op", dsp_op, VECS[i].op);
            chk("R3 opa from file", dsp_opa, m[VECS[i].sa]);
            chk("R3 opb from file", dsp_opb, m[VECS[i].sb]);
            tick;
            chk("R6 dispatched once", dsp_valid, 0);
            bcast(1, VECS[i].res);
            m[VECS[i].dst] = VECS[i].res;
            chk("R7 station freed", iss_ready, 1);
        end

        // Dependence through tag capture (R3, R5)
        issue(4'd1, 4'd8, 4'd1, 4'd1);
        tick;
        issue(4'd2, 4'd9, 4'd8, 4'd2);
        chk("R3 reader waits on producer", dsp_valid, 0);
        bcast(1, 64'hDEAD);
        m[8] = 64'hDEAD;
        chk("R5 wake after broadcast", dsp_valid, 1);
        chk("R5 waiter tag", dsp_tag, 2);
        chk("R5 captured opa", dsp_opa, 64'hDEAD);
        chk("R3 opb from file", dsp_opb, m[2]);
        tick;
        bcast(2, 64'hBEEF);
        m[9] = 64'hBEEF;

        // Same-cycle issue and broadcast (R4)
        issue(4'd3, 4'd10, 4'd1, 4'd1);
        tick;
        set_issue(4'd4, 4'd11, 4'd10, 4'd3);
        set_bcast(1, 64'hC0FFEE);
        tick;
        idle_inputs;
        m[10] = 64'hC0FFEE;
        chk("R4 bypass dispatch", dsp_valid, 1);
        chk("R4 bypass tag", dsp_tag, 2);
        chk("R4 bypass value", dsp_opa, 64'hC0FFEE);
        tick;
        bcast(2, 64'h55);
        m[11] = 64'h55;

        // Newer rename kept over stale broadcast (R8)
        issue(4'd5, 4'd12, 4'd1, 4'd1);
        tick;
        issue(4'd6, 4'd12, 4'd2, 4'd2);
        tick;
        bcast(1, 64'h1);
        issue(4'd7, 4'd13, 4'd12, 4'd12);
        chk("R8 stale broadcast kept rename", dsp_valid, 0);
        bcast(2, 64'h2222);
        m[12] = 64'h2222;
        chk("R8 reader wakes on newer tag", dsp_valid, 1);
        chk("R8 reader tag", dsp_tag, 1);
        chk("R8 value from newer producer", dsp_opa, 64'h2222);
        chk("R5 both sources captured", dsp_opb, 64'h2222);
        tick;
        bcast(1, 64'h33);
        m[13] = 64'h33;

        // Fill all stations, refused issue, tag reuse (R2, R7)
        for (int k = 0; k < NUM_STN; k++) begin
            issue(4'd8, reg_t'(4 + k), 4'd0, 4'd1);
            chk("R2 allocation order", dsp_tag, k + 1);
        end
        tick;
        chk("R2 ready low when full", iss_ready, 0);
        issue(4'd9, 4'd14, 4'd0, 4'd0);
        chk("R2 refused issue not dispatched", dsp_valid, 0);
        bcast(3, 64'h3333);
        m[6] = 64'h3333;
        chk("R7 ready after release", iss_ready, 1);
        issue(4'd10, 4'd1, 4'd14, 4'd14);
        chk("R2 refused issue left no rename", dsp_valid, 1);
        chk("R7 freed tag reused", dsp_tag, 3);
        chk("R2 register value untouched", dsp_opa, m[14]);
        tick;
        bcast(1, 64'h41); m[4] = 64'h41;
        bcast(2, 64'h42); m[5] = 64'h42;
        bcast(4, 64'h44); m[7] = 64'h44;
        bcast(3, 64'h43); m[1] = 64'h43;

        // Two waiters on one tag: capture and dispatch order (R5, R6)
        issue(4'd11, 4'd8, 4'd0, 4'd0);
        tick;
        issue(4'd12, 4'd9, 4'd8, 4'd1);
        issue(4'd13, 4'd10, 4'd2, 4'd8);
        chk("R6 no dispatch while waiting", dsp_valid, 0);
        bcast(1, 64'h4444);
        chk("R6 lowest ready first", dsp_tag, 2);
        chk("R5 first waiter opa", dsp_opa, 64'h4444);
        chk("R5 first waiter opb", dsp_opb, m[1]);
        tick;
        chk("R6 second waiter next", dsp_tag, 3);
        chk("R5 second waiter opa", dsp_opa, m[2]);
        chk("R5 second waiter opb", dsp_opb, 64'h4444);
        tick;
        chk("R6 nothing left", dsp_valid, 0);
        bcast(2, 64'h1); bcast(3, 64'h2);

        // Both sources pending on different producers (R6)
        issue(4'd1, 4'd11, 4'd1, 4'd1);
        tick;
        issue(4'd2, 4'd12, 4'd2, 4'd2);
        tick;
        issue(4'd3, 4'd13, 4'd11, 4'd12);
        bcast(1, 64'hA1);
        chk("R6 one source still pending", dsp_valid, 0);
        bcast(2, 64'hB2);
        chk("R6 both ready dispatch", dsp_tag, 3);
        chk("R5 opa captured", dsp_opa, 64'hA1);
        chk("R5 opb captured", dsp_opb, 64'hB2);
        tick;
        bcast(3, 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule